// File: doc/BRIEF.md
# Dual-Issue Pair Gate

This block decides, every cycle, how much of a two-instruction group may leave the decode stage of a two-wide, statically scheduled, in-order pipeline. The upstream stage hands over a pair of decoded instructions. Each lane carries a class code, a format bit (integer or floating point), two source register numbers and a destination register number. The gate holds the pair in a register. From the held pair it produces an issue mask: nothing, the older lane only, or both lanes.

The older lane issues unless it reads the destination of a load issued in the previous cycle. The younger lane joins it only in three cases: the two classes form an allowed combination, no register conflict links the two lanes, and the younger lane is itself free of a load-use stall. When only the older lane leaves, the younger one stays in place. The upstream stage is told to hold until the younger lane has also left, so a new pair never overtakes a leftover instruction.

Top module: `dual_issue_gate`

## Requirements
- R1: Lane 1 (the younger) issues only in a cycle where lane 0 also issues or lane 0 is empty. When lane 0 is blocked, lane 1 does not issue even if it is free of every conflict.
- R2: `up_ready` is high exactly when every valid held lane issues in the current cycle, or no lane is held. While it is low, the held lane 1 is kept unchanged even if `up_valid` is high.
- R3: Class codes are 0 operate, 1 load, 2 store and 3 branch. Format 0 is integer and format 1 is floating point. An integer operate pairs with a floating-point operate. A load pairs with an operate of either format. A store pairs with an operate only when both have the same format.
- R4: A branch pairs with a load or an operate of either format. It pairs with a store only when the two formats differ.
- R5: Two loads, two stores, two branches, or two operates of the same format never issue together: lane 0 issues alone.
- R6: Lane 1 does not pair with lane 0 under any of three register conflicts. The first is lane 1 reading lane 0's destination. The second is lane 1 writing a register that lane 0 reads. The third is both lanes writing the same register. Only operates and loads write their destination; the destination field of a store or branch is ignored.
- R7: Register number 0 never creates a dependence of any kind.
- R8: An instruction in either lane that reads the destination of a load issued in the previous cycle does not issue in this cycle. It can issue in the following cycle.
- R9: After reset no lane is held, no load is pending, `issue_mask` is 0 and `up_ready` is 1.
- R10: A pair is captured on a clock edge where `up_valid` and `up_ready` are both high. Each lane's presence is taken from `in_slot_valid`. `issue_mask` reflects the held pair in the following cycle. With `up_valid` low nothing is captured, and a bit of `issue_mask` is set only for a held lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream offers a new pair |
| in_slot_valid | input | 2 | Presence of each offered lane (bit 0 is the older) |
| in_cls | input | 2x2 | Class code per lane |
| in_fmt | input | 2 | Format bit per lane |
| in_src_a | input | 2x5 | First source register per lane |
| in_src_b | input | 2x5 | Second source register per lane |
| in_dst | input | 2x5 | Destination register per lane |
| up_ready | output | 1 | Gate accepts a new pair at the next edge |
| issue_mask | output | 2 | Lanes leaving this cycle (bit 0 older lane) |

## Verification
Two functions can meet in the same cycle: the partial issue of a pair, where lane 0 leaves and lane 1 is held, and the upstream handover of a new pair. The bench provokes this by keeping `up_valid` high, with the pair still on the inputs, through a same-unit stall. If the gate reloaded there, the held lane would show up as a second lane-0 issue. A load-use stall on lane 1 is also timed to coincide with a free lane 0, and a load-use stall on lane 0 is paired with an independent lane 1. For each case the scoreboard expects a specific per-cycle sequence of mask and ready values and compares it cycle by cycle.

// File: rtl/dig_pkg.sv
package dig_pkg;

    localparam int REG_W = 5;
    localparam int NSRC  = 2;
    localparam int LANES = 2;
    localparam int CLS_W = 2;

    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_OPER   = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_STORE  = 2'd2,
        CLS_BRANCH = 2'd3
    } iclass_e;

    typedef struct packed {
        logic                 valid;
        iclass_e              cls;
        logic                 fmt;
        reg_t [NSRC-1:0]      src;
        reg_t                 dst;
    } slot_t;

    // Operates and loads write their destination; register 0 never counts.
    function automatic logic writes_reg(slot_t s);
        return s.valid && (s.cls == CLS_OPER || s.cls == CLS_LOAD) && (s.dst != '0);
    endfunction

    function automatic logic reads_reg(slot_t s, reg_t r);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (s.src[i] == r) hit = 1'b1;
        end
        return s.valid && (r != '0) && hit;
    endfunction

endpackage

// File: rtl/dig_pair_table.sv
module dig_pair_table
    import dig_pkg::*;
(
    input  iclass_e cls_a,
    input  iclass_e cls_b,
    input  logic    fmt_a,
    input  logic    fmt_b,
    output logic    pair_ok
);

    iclass_e lo_cls;
    iclass_e hi_cls;
    logic    same_fmt;

    always_comb begin
        lo_cls   = (cls_a <= cls_b) ? cls_a : cls_b;
        hi_cls   = (cls_a <= cls_b) ? cls_b : cls_a;
        same_fmt = (fmt_a == fmt_b);
        case ({lo_cls, hi_cls})
            {CLS_OPER,  CLS_OPER}:   pair_ok = !same_fmt;   // int unit vs fp unit
            {CLS_OPER,  CLS_LOAD}:   pair_ok = 1'b1;
            {CLS_OPER,  CLS_STORE}:  pair_ok = same_fmt;    // shared result bus
            {CLS_OPER,  CLS_BRANCH}: pair_ok = 1'b1;
            {CLS_LOAD,  CLS_BRANCH}: pair_ok = 1'b1;
            {CLS_STORE, CLS_BRANCH}: pair_ok = !same_fmt;
            default:                 pair_ok = 1'b0;        // unlisted or same unit
        endcase
    end

    always_comb begin
        if (pair_ok && ((cls_a == CLS_STORE && cls_b == CLS_OPER) ||
                        (cls_b == CLS_STORE && cls_a == CLS_OPER))) begin
            p_store_oper_fmt_r3: assert (fmt_a == fmt_b);
        end
    end

endmodule

// File: rtl/dig_hazard_unit.sv
module dig_hazard_unit
    import dig_pkg::*;
(
    input  slot_t [LANES-1:0] slots,
    input  logic              ld_busy,
    input  reg_t              ld_dst,
    output logic              intra_haz,
    output logic [LANES-1:0]  ld_blk
);

    logic raw_hit;
    logic war_hit;
    logic waw_hit;

    for (genvar k = 0; k < LANES; k++) begin : g_ld
        assign ld_blk[k] = ld_busy && reads_reg(slots[k], ld_dst);
    end

    always_comb begin
        raw_hit   = writes_reg(slots[0]) && reads_reg(slots[1], slots[0].dst);
        war_hit   = writes_reg(slots[1]) && reads_reg(slots[0], slots[1].dst);
        waw_hit   = writes_reg(slots[0]) && writes_reg(slots[1]) &&
                    (slots[0].dst == slots[1].dst);
        intra_haz = raw_hit || war_hit || waw_hit;
    end

endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate
    import dig_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         up_valid,
    input  logic [LANES-1:0]             in_slot_valid,
    input  logic [LANES-1:0][CLS_W-1:0]  in_cls,
    input  logic [LANES-1:0]             in_fmt,
    input  logic [LANES-1:0][REG_W-1:0]  in_src_a,
    input  logic [LANES-1:0][REG_W-1:0]  in_src_b,
    input  logic [LANES-1:0][REG_W-1:0]  in_dst,
    output logic                         up_ready,
    output logic [LANES-1:0]             issue_mask
);

    typedef struct packed {
        slot_t [LANES-1:0] slot;
        logic              ld_busy;
        reg_t              ld_dst;
    } state_t;

    state_t            st_d, st_q;
    logic              pair_ok;
    logic              intra_haz;
    logic [LANES-1:0]  ld_blk;
    logic [LANES-1:0]  iss;
    logic              ready;
    logic              go0, go1;

    dig_pair_table u_table (
        .cls_a   (st_q.slot[0].cls),
        .cls_b   (st_q.slot[1].cls),
        .fmt_a   (st_q.slot[0].fmt),
        .fmt_b   (st_q.slot[1].fmt),
        .pair_ok (pair_ok)
    );

    dig_hazard_unit u_haz (
        .slots     (st_q.slot),
        .ld_busy   (st_q.ld_busy),
        .ld_dst    (st_q.ld_dst),
        .intra_haz (intra_haz),
        .ld_blk    (ld_blk)
    );

    always_comb begin
        go0 = st_q.slot[0].valid && !ld_blk[0];
        go1 = st_q.slot[1].valid && !ld_blk[1] &&
              (!st_q.slot[0].valid || (go0 && pair_ok && !intra_haz));
        iss = {go1, go0};

        ready = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (st_q.slot[k].valid && !iss[k]) ready = 1'b0;
        end

        st_d         = st_q;
        st_d.ld_busy = 1'b0;
        st_d.ld_dst  = '0;
        for (int k = 0; k < LANES; k++) begin
            if (iss[k]) begin
                st_d.slot[k].valid = 1'b0;
                if (st_q.slot[k].cls == CLS_LOAD && st_q.slot[k].dst != '0) begin
                    st_d.ld_busy = 1'b1;
                    st_d.ld_dst  = st_q.slot[k].dst;
                end
            end
        end

        if (ready && up_valid) begin
            for (int k = 0; k < LANES; k++) begin
                st_d.slot[k].valid  = in_slot_valid[k];
                st_d.slot[k].cls    = iclass_e'(in_cls[k]);
                st_d.slot[k].fmt    = in_fmt[k];
                st_d.slot[k].src[0] = in_src_a[k];
                st_d.slot[k].src[1] = in_src_b[k];
                st_d.slot[k].dst    = in_dst[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue_mask = iss;
    assign up_ready   = ready;

    p_in_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_mask[1] && st_q.slot[0].valid) |-> issue_mask[0]);

    p_hold_slot1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !up_ready |=> $stable(st_q.slot[1]));

    p_no_twin_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_mask == 2'b11) |->
        !((st_q.slot[0].cls == st_q.slot[1].cls) && (st_q.slot[0].fmt == st_q.slot[1].fmt)));

    p_no_waw_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_mask == 2'b11) && writes_reg(st_q.slot[0]) && writes_reg(st_q.slot[1])) |->
        (st_q.slot[0].dst != st_q.slot[1].dst));

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        p_load_use_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_mask[k] && st_q.slot[k].cls == CLS_LOAD && st_q.slot[k].dst != '0) |=>
            !(issue_mask[0] && reads_reg(st_q.slot[0], $past(st_q.slot[k].dst))));

        p_mask_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
            issue_mask[k] |-> st_q.slot[k].valid);
    end

endmodule

// File: tb/sim_dual_issue_gate.sv
module sim_dual_issue_gate;
    import dig_pkg::*;

    localparam logic INT = 1'b0;
    localparam logic FP  = 1'b1;

    logic                         clk;
    logic                         rst_n;
    logic                         up_valid;
    logic [LANES-1:0]             in_slot_valid;
    logic [LANES-1:0][CLS_W-1:0]  in_cls;
    logic [LANES-1:0]             in_fmt;
    logic [LANES-1:0][REG_W-1:0]  in_src_a;
    logic [LANES-1:0][REG_W-1:0]  in_src_b;
    logic [LANES-1:0][REG_W-1:0]  in_dst;
    logic                         up_ready;
    logic [LANES-1:0]             issue_mask;

    int n_checks = 0;
    int n_fails  = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    dual_issue_gate u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_valid      (up_valid),
        .in_slot_valid (in_slot_valid),
        .in_cls        (in_cls),
        .in_fmt        (in_fmt),
        .in_src_a      (in_src_a),
        .in_src_b      (in_src_b),
        .in_dst        (in_dst),
        .up_ready      (up_ready),
        .issue_mask    (issue_mask)
    );

    initial clk = 1'b0;
    always #2ns clk = ~clk;

    function automatic slot_t mk(iclass_e c, logic f, reg_t a, reg_t b, reg_t d);
        slot_t s;
        s.valid  = 1'b1;
        s.cls    = c;
        s.fmt    = f;
        s.src[0] = a;
        s.src[1] = b;
        s.dst    = d;
        return s;
    endfunction

    task automatic drive(slot_t a, slot_t b);
        in_slot_valid = {b.valid, a.valid};
        in_cls        = {b.cls, a.cls};
        in_fmt        = {b.fmt, a.fmt};
        in_src_a      = {b.src[0], a.src[0]};
        in_src_b      = {b.src[1], a.src[1]};
        in_dst        = {b.dst, a.dst};
    endtask

    // Called right after a negedge. Item k is the expected {ready, mask} k cycles
    // after the pair is captured; em holds masks as {item2, item1, item0}.
    task automatic play(slot_t a, slot_t b, logic hold, int n,
                        logic [5:0] em, logic [2:0] er, string tag);
        up_valid = 1'b1;
        drive(a, b);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back({er[k], em[2*k +: 2]});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        if (!hold) up_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic check(logic [2:0] got, logic [2:0] exp, string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: {ready,mask} got %b expected %b", tag, got, exp);
        end
    endtask

    // Monitor: one expected item per cycle once a pair is in flight.
    initial begin
        forever begin
            @(posedge clk);
            #1ns;
            if (exp_q.size() != 0) begin
                check({up_ready, issue_mask}, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #200us;
        n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        up_valid = 1'b0;
        drive('0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: empty after reset
        check({2'b00, up_ready}, 3'b001, "R9 up_ready after reset");
        check({1'b0, issue_mask}, 3'b000, "R9 issue_mask after reset");

        play(mk(CLS_OPER, INT, 2, 3, 1), mk(CLS_OPER, FP, 5, 6, 4), 0, 1,
             6'b000011, 3'b001, "R3 int operate with fp operate");
        // R2: up_valid stays high with the same pair during the hold
        play(mk(CLS_OPER, INT, 2, 3, 1), mk(CLS_OPER, INT, 8, 9, 7), 1, 2,
             6'b001001, 3'b010, "R5 same-format operates, R2 hold");
        play(mk(CLS_LOAD, INT, 11, 0, 10), mk(CLS_OPER, INT, 13, 14, 12), 0, 1,
             6'b000011, 3'b001, "R3 load with operate");
        play(mk(CLS_OPER, INT, 10, 2, 15), '0, 0, 2,
             6'b000100, 3'b010, "R8 use right after load");
        play(mk(CLS_STORE, INT, 3, 4, 0), mk(CLS_OPER, INT, 6, 7, 5), 0, 1,
             6'b000011, 3'b001, "R3 store with same-format operate");
        play(mk(CLS_STORE, FP, 3, 4, 0), mk(CLS_OPER, INT, 6, 7, 5), 0, 2,
             6'b001001, 3'b010, "R3 store with other-format operate");
        play(mk(CLS_STORE, FP, 1, 2, 0), mk(CLS_BRANCH, INT, 3, 0, 0), 0, 1,
             6'b000011, 3'b001, "R4 branch with other-format store");
        play(mk(CLS_STORE, FP, 1, 2, 0), mk(CLS_BRANCH, FP, 3, 0, 0), 0, 2,
             6'b001001, 3'b010, "R4 branch with same-format store");
        play(mk(CLS_BRANCH, INT, 1, 0, 0), mk(CLS_LOAD, FP, 2, 0, 21), 0, 1,
             6'b000011, 3'b001, "R4 branch with load");
        play(mk(CLS_LOAD, INT, 1, 0, 22), mk(CLS_LOAD, INT, 2, 0, 23), 0, 2,
             6'b001001, 3'b010, "R5 two loads");
        play(mk(CLS_OPER, INT, 1, 2, 5), mk(CLS_OPER, FP, 5, 3, 6), 0, 2,
             6'b001001, 3'b010, "R6 read after write in pair");
        play(mk(CLS_OPER, INT, 8, 9, 7), mk(CLS_OPER, FP, 1, 2, 8), 0, 2,
             6'b001001, 3'b010, "R6 write after read in pair");
        play(mk(CLS_OPER, INT, 1, 2, 7), mk(CLS_OPER, FP, 3, 4, 7), 0, 2,
             6'b001001, 3'b010, "R6 write after write in pair");
        play(mk(CLS_OPER, INT, 1, 2, 0), mk(CLS_OPER, FP, 0, 0, 0), 0, 1,
             6'b000011, 3'b001, "R7 register zero exempt");
        play(mk(CLS_BRANCH, INT, 1, 0, 0), mk(CLS_BRANCH, FP, 2, 0, 0), 0, 2,
             6'b001001, 3'b010, "R5 two branches");
        play(mk(CLS_STORE, INT, 3, 4, 9), mk(CLS_BRANCH, FP, 9, 0, 0), 0, 1,
             6'b000011, 3'b001, "R6 store destination ignored");
        play(mk(CLS_LOAD, INT, 1, 0, 24), '0, 0, 1,
             6'b000001, 3'b001, "R8 lone load");
        play(mk(CLS_OPER, INT, 1, 2, 3), mk(CLS_OPER, FP, 24, 5, 6), 0, 2,
             6'b001001, 3'b010, "R8 lane 1 waits on load");
        play(mk(CLS_LOAD, INT, 1, 0, 25), '0, 0, 1,
             6'b000001, 3'b001, "R8 lone load");
        play(mk(CLS_OPER, INT, 25, 2, 3), mk(CLS_OPER, FP, 7, 8, 9), 0, 2,
             6'b001100, 3'b010, "R1 blocked lane 0 holds lane 1");
        play(mk(CLS_OPER, INT, 2, 3, 1), mk(CLS_LOAD, INT, 4, 0, 26), 0, 1,
             6'b000011, 3'b001, "R3 load in lane 1");
        play(mk(CLS_OPER, INT, 26, 2, 27), '0, 0, 2,
             6'b000100, 3'b010, "R8 use of lane 1 load");
        play('0, '0, 0, 1, 6'b000000, 3'b001, "R10 empty pair captured");

        // R10: a valid pair on the inputs with up_valid low is not captured
        up_valid = 1'b0;
        drive(mk(CLS_OPER, INT, 1, 2, 3), mk(CLS_OPER, FP, 4, 5, 6));
        for (int k = 0; k < 2; k++) begin
            exp_q.push_back(3'b100);
            tag_q.push_back("R10 no capture without up_valid");
        end
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule